// File: doc/BRIEF.md
# Short Relative Branch Resolver

This block resolves a short conditional branch. It takes a 4-bit condition selector, an 8-bit signed word displacement, the address of the 32-bit instruction word that holds the branch, and the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). From these it decides whether the branch is taken and computes where it goes.

The displacement counts whole 32-bit words. It is measured from the start of the instruction word that follows the one holding the branch. A taken branch with displacement zero therefore lands on the next word, and skips a short instruction packed into the second half of the current word. A displacement of minus one lands back on the word that holds the branch.

The result is registered. It appears one cycle after a `valid_i` strobe and stays there until the next strobe.

Top module: `brc_unit`

## Requirements
- R1: During and immediately after reset, `done_o`, `taken_o` and `target_o` are all zero.
- R2: `done_o` is 1 in exactly the cycle after a cycle with `valid_i`=1, and 0 otherwise. `taken_o` and `target_o` update in that same cycle.
- R3: `target_o` equals the word base, plus 4, plus the sign-extended `disp_i` times 4, all modulo 2^32. The word base is `word_addr_i` with bits [1:0] cleared. The low two bits of `target_o` are therefore always zero.
- R4: With `disp_i`=0, `target_o` is the word base plus 4. This skips the second halfword of the branch's own word, and the sum wraps past the top of the address space.
- R5: `disp_i` is two's complement. 0xFF (-1) gives the branch's own word base, and 0x80 (-128) gives the word base minus 508.
- R6: The selector codes for signed comparisons are: 1 taken when N^V, 2 when Z, 3 when (N^V)|Z, 4 when !((N^V)|Z), 5 when !Z, and 6 when !(N^V).
- R7: The selector codes for the remaining conditions are: 7 always taken, 8 when V, 9 when !V, 10 (0xA) when C, and 11 (0xB) when !C.
- R8: Selector values 0, 12, 13, 14 and 15 never give `taken_o`=1, whatever the flags are.
- R9: While `valid_i` is 0, `taken_o` and `target_o` keep their last values, however the other inputs change.
- R10: Bits [1:0] of `word_addr_i` have no effect on `target_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: resolve the branch on the inputs this cycle |
| sel_i | input | 4 | Condition selector code |
| disp_i | input | 8 | Signed displacement in 32-bit words |
| word_addr_i | input | 32 | Byte address of the instruction word that holds the branch |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| done_o | output | 1 | Result valid, one cycle after the strobe |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 32 | Branch target byte address |

## Verification
The decision is checked against all 16 selector codes crossed with all 16 flag combinations. This separates the signed comparisons from one another, separates each flag test from its inverse, and confirms that the reserved codes never fire.

The target is checked across all 256 displacements at three word addresses:
- an aligned address, which shows the sign extension and the word scaling;
- an unaligned address, which shows that the low two bits are dropped;
- an address near the top of memory, which shows wrap-around.

Separate strobe-free cycles with changed inputs show that the registered result holds between strobes.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_RSVD0 = 4'h0,
        SEL_LT    = 4'h1,
        SEL_EQ    = 4'h2,
        SEL_LE    = 4'h3,
        SEL_GT    = 4'h4,
        SEL_NE    = 4'h5,
        SEL_GE    = 4'h6,
        SEL_ALW   = 4'h7,
        SEL_OVF   = 4'h8,
        SEL_NOVF  = 4'h9,
        SEL_CRY   = 4'hA,
        SEL_NCRY  = 4'hB,
        SEL_RSVDC = 4'hC,
        SEL_RSVDD = 4'hD,
        SEL_RSVDE = 4'hE,
        SEL_RSVDF = 4'hF
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } flags_t;

    // Signed "less than" after a compare: the sign flag, corrected by overflow.
    function automatic logic signed_less(input flags_t f);
        return f.neg ^ f.ovf;
    endfunction

    function automatic logic signed_less_eq(input flags_t f);
        return signed_less(f) | f.zero;
    endfunction

    function automatic logic cond_holds(input cond_sel_e sel, input flags_t f);
        logic res;
        unique case (sel)
            SEL_LT:   res = signed_less(f);
            SEL_EQ:   res = f.zero;
            SEL_LE:   res = signed_less_eq(f);
            SEL_GT:   res = ~signed_less_eq(f);
            SEL_NE:   res = ~f.zero;
            SEL_GE:   res = ~signed_less(f);
            SEL_ALW:  res = 1'b1;
            SEL_OVF:  res = f.ovf;
            SEL_NOVF: res = ~f.ovf;
            SEL_CRY:  res = f.cry;
            SEL_NCRY: res = ~f.cry;
            default:  res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  flags_t           flags_i,
    output logic             taken_o
);
    cond_sel_e sel;

    always_comb begin
        sel     = cond_sel_e'(sel_i);
        taken_o = cond_holds(sel, flags_i);
    end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DISP_W     = 8,
    parameter int unsigned UNIT_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] word_addr_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int unsigned UNIT_BYTES = 1 << UNIT_SHIFT;
    localparam int unsigned REL_W      = DISP_W + 1;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(UNIT_BYTES - 1);

    logic [ADDR_W-1:0] base;
    logic [REL_W-1:0]  rel;
    logic [ADDR_W-1:0] rel_ext;
    logic [ADDR_W-1:0] offset;

    // The "+1 word" step is folded into the narrow displacement.
    // Only one full-width adder remains.
    always_comb begin
        base     = word_addr_i & ~LOW_MASK;
        rel      = {disp_i[DISP_W-1], disp_i} + {{DISP_W{1'b0}}, 1'b1};
        rel_ext  = {{(ADDR_W-REL_W){rel[REL_W-1]}}, rel};
        offset   = rel_ext << UNIT_SHIFT;
        target_o = base + offset;
    end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DISP_W     = 8,
    parameter int unsigned UNIT_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        sel_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] word_addr_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    output logic              done_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << UNIT_SHIFT) - 1);

    flags_t            flags;
    logic              taken_c;
    logic [ADDR_W-1:0] target_c;

    assign flags = '{neg: flag_n_i, zero: flag_z_i, ovf: flag_v_i, cry: flag_c_i};

    brc_cond_eval u_cond (
        .sel_i   (sel_i),
        .flags_i (flags),
        .taken_o (taken_c)
    );

    brc_target_gen #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_tgt (
        .word_addr_i (word_addr_i),
        .disp_i      (disp_i),
        .target_o    (target_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            taken_o  <= 1'b0;
            target_o <= '0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                taken_o  <= taken_c;
                target_o <= target_c;
            end
        end
    end

    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);
    p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(taken_o) && $stable(target_o)));
    p_target_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((target_o & LOW_MASK) == '0));
    p_always_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sel_i == 4'h7) |=> taken_o);
    p_reserved_never_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (sel_i == 4'h0 || sel_i >= 4'hC)) |=> !taken_o);
    p_eq_follows_z_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sel_i == 4'h2) |=> (taken_o == $past(flag_z_i)));
endmodule

// File: tb/brc_unit_tb_top.sv
module brc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  sel_i = '0;
    logic [7:0]  disp_i = '0;
    logic [31:0] word_addr_i = '0;
    logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0;
    logic        done_o, taken_o;
    logic [31:0] target_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    brc_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .sel_i(sel_i), .disp_i(disp_i),
        .word_addr_i(word_addr_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .flag_v_i(flag_v_i), .flag_c_i(flag_c_i),
        .done_o(done_o), .taken_o(taken_o), .target_o(target_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic exp_taken(input int s, input logic n, z, v, c);
        logic lt, le;
        lt = n ^ v;
        le = lt | z;
        case (s)
            1: return lt;
            2: return z;
            3: return le;
            4: return !le;
            5: return !z;
            6: return !lt;
            7: return 1'b1;
            8: return v;
            9: return !v;
            10: return c;
            11: return !c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(input logic [31:0] a, input logic [7:0] d);
        longint base, sd;
        base = longint'(a) & 64'hFFFF_FFFC;
        sd   = longint'($signed(d));
        return 32'(base + 4 + sd * 4);
    endfunction

    // Drive on a falling edge, strobe for one cycle, then sample on the next falling edge.
    task automatic issue(input logic [3:0] s, input logic [7:0] d, input logic [31:0] a,
                         input logic [3:0] f);
        @(negedge clk);
        sel_i = s; disp_i = d; word_addr_i = a;
        {flag_n_i, flag_z_i, flag_v_i, flag_c_i} = f;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held_t;
        logic        held_k;

        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'b0, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", {31'b0, done_o}, 0);
        check("R1 taken after reset", {31'b0, taken_o}, 0);
        check("R1 target after reset", target_o, 0);

        // R6 R7 R8: every selector crossed with every flag combination.
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] fl;
                fl = 4'(f);
                issue(4'(s), 8'h00, 32'h100, fl);
                check("R2 done strobe", {31'b0, done_o}, 1);
                check((s >= 1 && s <= 6) ? "R6 signed cond" :
                      ((s >= 7 && s <= 11) ? "R7 flag cond" : "R8 reserved"),
                      {31'b0, taken_o},
                      {31'b0, exp_taken(s, fl[3], fl[2], fl[1], fl[0])});
            end
        end

        // R3 R5 R10 R4: every displacement at three word addresses.
        for (int k = 0; k < 3; k++) begin
            logic [31:0] a;
            a = (k == 0) ? 32'h0000_1000 : ((k == 1) ? 32'h0000_2003 : 32'hFFFF_FFF8);
            for (int d = 0; d < 256; d++) begin
                issue(4'h7, 8'(d), a, 4'h0);
                check(k == 1 ? "R10 unaligned addr" : "R3 target", target_o,
                      exp_target(a, 8'(d)));
            end
        end

        issue(4'h7, 8'h00, 32'h0000_1000, 4'h0);
        check("R4 zero disp skips half", target_o, 32'h0000_1004);
        issue(4'h7, 8'h00, 32'hFFFF_FFFC, 4'h0);
        check("R4 zero disp wraps", target_o, 32'h0000_0000);
        issue(4'h7, 8'hFF, 32'h0000_1002, 4'h0);
        check("R5 minus one own word", target_o, 32'h0000_1000);
        issue(4'h7, 8'h80, 32'h0000_1000, 4'h0);
        check("R5 most negative", target_o, 32'h0000_1000 - 32'd508);
        issue(4'h7, 8'h7F, 32'h0000_1000, 4'h0);
        check("R3 most positive", target_o, 32'h0000_1200);

        // R9: inputs change with no strobe; outputs must hold.
        issue(4'h2, 8'h10, 32'h0000_4000, 4'b0100);
        held_t = target_o;
        held_k = taken_o;
        @(negedge clk);
        sel_i = 4'h5; disp_i = 8'hF0; word_addr_i = 32'h0000_8000;
        {flag_n_i, flag_z_i, flag_v_i, flag_c_i} = 4'b0000;
        repeat (2) @(negedge clk);
        check("R9 taken held", {31'b0, taken_o}, {31'b0, held_k});
        check("R9 target held", target_o, held_t);
        check("R2 done low without strobe", {31'b0, done_o}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule